// File: doc/BRIEF.md
# Hashed Page Table Group Search

This block finds the page table entry that translates an effective page inside a known segment. The caller supplies the segment's virtual segment identifier, a flag for a 1 TB segment (clear means 256 MB), the segment's base page shift and the effective page number, which is the byte offset of the address inside its segment. The block hashes these values to select a group of eight 16-byte entries in a hashed table held in memory. It reads the entries one at a time over a valid/ready read port and tests each one. If no entry in that group is accepted, it searches a second group chosen by the bitwise complement of the same hash. It then raises a one-cycle `done` with the result.

An entry is accepted only when two tests pass. First, its first word must equal a compare word built from the segment and page number under a fixed mask. Second, its page-size encoding must decode to a valid actual page size for this segment. An entry that passes the first test and fails the second is skipped, and the scan goes on. The table base (aligned to the table size), the table mask, the size-encoding list and the large-page inhibit control are quasi-static: they must stay unchanged while a search is in progress.

The request side accepts a search when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high only while the block is idle. On the memory side, the block holds `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready` takes them, so the memory may stall it for any number of cycles. Only one read is outstanding at a time. The response is taken on the first cycle that `mem_rsp_valid` is high and cannot be refused.

Top module: `hpt_group_search`

## Requirements
- R1: `req_ready` is high exactly when no search is in progress, including directly after reset. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Every search ends with `done` high for exactly one cycle, after which `req_ready` returns.
- R2: For a 256 MB segment, hash = VSID xor (EPN >> s), where s is the effective base shift. Entry k (0..7) of a group with hash h is read at byte address `tbl_base | ((h & tbl_mask) << 7)` plus 16·k, and the reads run in order of increasing k.
- R3: For a 1 TB segment, hash = VSID xor (VSID << 25) xor (EPN >> s).
- R4: A memory request holds its address and stays valid until it is accepted, and the next request is issued only after the previous response. Response bits 63:0 carry the first entry word and bits 127:64 carry the second.
- R5: The compare word is built as follows. Bits 63:62 are the segment-size code: 01 for 1 TB, 00 for 256 MB. Bits 61:12 hold the VSID, placed starting at bit 24 for 1 TB and at bit 12 for 256 MB. OR into that ((EPN with its low s bits cleared) >> 16) masked to bits 61:7. Bit 0 (valid) is 1 and bit 1 (secondary) is 0. A first word matches when (word xor compare) and 0xFFFFFFFFFFFFFF83 is zero, so bits 6:2 are ignored.
- R6: The secondary group, addressed with ~hash and compared with bit 1 of the compare word set, is read only after all eight primary entries are rejected.
- R7: For an entry whose first-word bit 2 is clear, the page shift is 12 when the base shift is 12. For any other base shift the entry is rejected.
- R8: For an entry whose first-word bit 2 is set, the size list is walked from slot 0. A slot whose shift is 0 ends the walk with no match. A slot whose shift is 12 is passed over. Slot i matches when (second word and (2^shift − 1) and 0x0FFFFFFFFFFFF000) equals its code << 12. The first slot that matches gives the page shift.
- R9: An entry that matches the compare word but whose size fails to decode is skipped, and the search continues with the next entry.
- R10: While `lp_inhibit` is high, the effective base shift is 12 for the hash, the compare word and the size decode, whatever `req_base_shift` is.
- R11: When all sixteen entries are rejected, `done` rises with `hit` low and `page_shift` zero.
- R12: On a hit, `pte_offset` is the table-relative byte offset of the entry, `pte_word0` and `pte_word1` are its two words, and `page_shift` is the decoded shift. These values hold until the next search ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Search request valid |
| req_ready | output | 1 | Block idle, able to take a request |
| req_vsid | input | VSID_W (50) | Virtual segment identifier |
| req_seg_1t | input | 1 | 1 = 1 TB segment, 0 = 256 MB |
| req_base_shift | input | 6 | Segment base page shift |
| req_epn | input | 64 | Effective page number (byte offset in segment) |
| lp_inhibit | input | 1 | Clamp the base shift to 12 |
| tbl_base | input | 64 | Table base address, aligned to the table size |
| tbl_mask | input | 64 | Mask applied to the hash |
| sz_shift | input | NUM_SIZES·6 (24) | Size list shifts, slot i at bits 6i+5:6i, 0 = empty |
| sz_code | input | NUM_SIZES·ENC_W (32) | Size list codes, slot i at bits ENC_W·i upward |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 128 | {second word, first word} |
| done | output | 1 | One-cycle end-of-search pulse |
| hit | output | 1 | An entry was accepted |
| pte_offset | output | 64 | Table-relative offset of the accepted entry |
| pte_word0 | output | 64 | First word of the accepted entry |
| pte_word1 | output | 64 | Second word of the accepted entry |
| page_shift | output | 6 | Decoded actual page shift, 0 on a miss |

## Verification
The bench keeps the default parameters: eight entries per group, a four-slot size list and a 128-group table mask, so a full double miss costs sixteen reads. It reloads the size list between searches. This covers a list that begins with a 4 KB slot, a list with an empty slot ahead of a usable one, and segment base shifts of 12, 16 and 24, including 24 under the inhibit control. The memory grants and answers reads with random stalls, so every search runs under back-pressure and the address sequence is checked read by read.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int WORD_W  = 64;
  localparam int SHIFT_W = 6;
  localparam logic [WORD_W-1:0] CMP_MASK   = 64'hFFFF_FFFF_FFFF_FF83;
  localparam logic [WORD_W-1:0] AVPN_MASK  = 64'h3FFF_FFFF_FFFF_FF80;
  localparam logic [WORD_W-1:0] VSID_FIELD = 64'h3FFF_FFFF_FFFF_F000;
  localparam logic [WORD_W-1:0] RPN_MASK   = 64'h0FFF_FFFF_FFFF_F000;
  localparam logic [WORD_W-1:0] SEG_1T_CODE = 64'h4000_0000_0000_0000;
  localparam int LARGE_BIT = 2;
  localparam int SEC_BIT   = 1;
  localparam logic [SHIFT_W-1:0] SMALL_SHIFT = 6'd12;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_DONE  = 2'd3
  } walk_state_t;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash
  import hpt_pkg::*;
#(
  parameter int VSID_W = 50
) (
  input  logic [VSID_W-1:0]  vsid,
  input  logic               seg_1t,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [WORD_W-1:0]  epn,
  output logic [WORD_W-1:0]  hash,
  output logic [WORD_W-1:0]  cmp_word
);
  logic [WORD_W-1:0] vs, epn_m, pn, seg_bits;

  assign vs    = WORD_W'(vsid);
  assign epn_m = epn & ~((WORD_W'(1) << shift) - WORD_W'(1));
  assign pn    = epn_m >> shift;

  always_comb begin
    if (seg_1t) begin
      hash     = vs ^ (vs << 25) ^ pn;
      seg_bits = SEG_1T_CODE | ((vs << 24) & VSID_FIELD);
    end else begin
      hash     = vs ^ pn;
      seg_bits = (vs << 12) & VSID_FIELD;
    end
  end

  // valid bit forced, secondary bit left for the walker to set
  assign cmp_word = seg_bits | ((epn_m >> 16) & AVPN_MASK) | WORD_W'(1);
endmodule

// File: rtl/hpt_size_decode.sv
module hpt_size_decode
  import hpt_pkg::*;
#(
  parameter int NUM_SIZES = 4,
  parameter int ENC_W     = 8
) (
  input  logic [SHIFT_W-1:0]         base_shift,
  input  logic [WORD_W-1:0]          pte0,
  input  logic [WORD_W-1:0]          pte1,
  input  logic [NUM_SIZES*SHIFT_W-1:0] sz_shift,
  input  logic [NUM_SIZES*ENC_W-1:0] sz_code,
  output logic [SHIFT_W-1:0]         shift_out
);
  logic [SHIFT_W-1:0] slot_sh [NUM_SIZES];
  logic [NUM_SIZES-1:0] slot_hit;

  for (genvar gi = 0; gi < NUM_SIZES; gi++) begin : g_slot
    logic [WORD_W-1:0] fmask, want;
    assign slot_sh[gi] = sz_shift[gi*SHIFT_W +: SHIFT_W];
    assign fmask = ((WORD_W'(1) << slot_sh[gi]) - WORD_W'(1)) & RPN_MASK;
    assign want  = WORD_W'(sz_code[gi*ENC_W +: ENC_W]) << 12;
    assign slot_hit[gi] = (slot_sh[gi] != SMALL_SHIFT) && ((pte1 & fmask) == want);
  end

  logic walk_end;
  always_comb begin
    shift_out = '0;
    walk_end  = 1'b0;
    if (!pte0[LARGE_BIT]) begin
      shift_out = (base_shift == SMALL_SHIFT) ? SMALL_SHIFT : '0;
    end else begin
      for (int i = 0; i < NUM_SIZES; i++) begin
        if (!walk_end) begin
          if (slot_sh[i] == '0) begin
            walk_end = 1'b1;
          end else if (slot_hit[i]) begin
            shift_out = slot_sh[i];
            walk_end  = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/hpt_group_search.sv
module hpt_group_search
  import hpt_pkg::*;
#(
  parameter int VSID_W        = 50,
  parameter int NUM_SIZES     = 4,
  parameter int ENC_W         = 8,
  parameter int GROUP_ENTRIES = 8,
  parameter int ENTRY_BYTES   = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [VSID_W-1:0]            req_vsid,
  input  logic                         req_seg_1t,
  input  logic [5:0]                   req_base_shift,
  input  logic [63:0]                  req_epn,
  input  logic                         lp_inhibit,
  input  logic [63:0]                  tbl_base,
  input  logic [63:0]                  tbl_mask,
  input  logic [NUM_SIZES*6-1:0]       sz_shift,
  input  logic [NUM_SIZES*ENC_W-1:0]   sz_code,
  output logic                         mem_req_valid,
  input  logic                         mem_req_ready,
  output logic [63:0]                  mem_req_addr,
  input  logic                         mem_rsp_valid,
  input  logic [127:0]                 mem_rsp_data,
  output logic                         done,
  output logic                         hit,
  output logic [63:0]                  pte_offset,
  output logic [63:0]                  pte_word0,
  output logic [63:0]                  pte_word1,
  output logic [5:0]                   page_shift
);
  localparam int IDX_W    = $clog2(GROUP_ENTRIES);
  localparam int ENTRY_SH = $clog2(ENTRY_BYTES);
  localparam int GROUP_SH = IDX_W + ENTRY_SH;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);

  walk_state_t st;
  logic [WORD_W-1:0]  hash_q, cmp_q;
  logic [SHIFT_W-1:0] shift_q;
  logic               sec_q;
  logic [IDX_W-1:0]   idx_q;

  // request-side hash and compare word
  logic [SHIFT_W-1:0] eff_shift;
  logic [WORD_W-1:0]  new_hash, new_cmp;
  assign eff_shift = lp_inhibit ? SMALL_SHIFT : req_base_shift;

  hpt_hash #(.VSID_W(VSID_W)) u_hash (
    .vsid(req_vsid), .seg_1t(req_seg_1t), .shift(eff_shift), .epn(req_epn),
    .hash(new_hash), .cmp_word(new_cmp)
  );

  // entry address for the current slot
  logic [WORD_W-1:0] grp_off, entry_off, cmp_cur;
  assign grp_off   = ((sec_q ? ~hash_q : hash_q) & tbl_mask) << GROUP_SH;
  assign entry_off = grp_off | (WORD_W'(idx_q) << ENTRY_SH);
  assign cmp_cur   = cmp_q | (WORD_W'(sec_q) << SEC_BIT);

  // candidate test
  logic [WORD_W-1:0]  w0, w1;
  logic [SHIFT_W-1:0] dec_shift;
  logic               tag_ok, take;
  assign w0     = mem_rsp_data[63:0];
  assign w1     = mem_rsp_data[127:64];
  assign tag_ok = ((w0 ^ cmp_cur) & CMP_MASK) == '0;

  hpt_size_decode #(.NUM_SIZES(NUM_SIZES), .ENC_W(ENC_W)) u_dec (
    .base_shift(shift_q), .pte0(w0), .pte1(w1),
    .sz_shift(sz_shift), .sz_code(sz_code), .shift_out(dec_shift)
  );
  assign take = tag_ok && (dec_shift != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      hash_q     <= '0;
      cmp_q      <= '0;
      shift_q    <= '0;
      sec_q      <= 1'b0;
      idx_q      <= '0;
      hit        <= 1'b0;
      pte_offset <= '0;
      pte_word0  <= '0;
      pte_word1  <= '0;
      page_shift <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          hash_q  <= new_hash;
          cmp_q   <= new_cmp;
          shift_q <= eff_shift;
          sec_q   <= 1'b0;
          idx_q   <= '0;
          st      <= S_ISSUE;
        end
        S_ISSUE: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (take) begin
            hit        <= 1'b1;
            pte_offset <= entry_off;
            pte_word0  <= w0;
            pte_word1  <= w1;
            page_shift <= dec_shift;
            st         <= S_DONE;
          end else if (idx_q != LAST_IDX) begin
            idx_q <= idx_q + 1'b1;
            st    <= S_ISSUE;
          end else if (!sec_q) begin
            sec_q <= 1'b1;
            idx_q <= '0;
            st    <= S_ISSUE;
          end else begin
            hit        <= 1'b0;
            pte_offset <= '0;
            pte_word0  <= '0;
            pte_word1  <= '0;
            page_shift <= '0;
            st         <= S_DONE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_ISSUE);
  assign mem_req_addr  = tbl_base | entry_off;
  assign done          = (st == S_DONE);
endmodule

// File: rtl/hpt_group_search_chk.sv
module hpt_group_search_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [63:0] mem_req_addr,
  input logic        mem_rsp_valid,
  input logic        done,
  input logic        hit,
  input logic [3:0]  off_low,
  input logic        w0_valid,
  input logic [5:0]  page_shift
);
  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || done) |-> !req_ready);
  // R1
  done_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_rsp_valid));
  // R12
  hit_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && hit |-> page_shift != 6'd0 && w0_valid && off_low == 4'd0);
  // R11
  miss_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !hit |-> page_shift == 6'd0);
endmodule

bind hpt_group_search hpt_group_search_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .done(done), .hit(hit), .off_low(pte_offset[3:0]),
  .w0_valid(pte_word0[0]), .page_shift(page_shift)
);

// File: tb/tb_hpt_group_search.sv
module tb_hpt_group_search;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int EW = 8;
  localparam int VW = 50;
  localparam logic [63:0] TBL_BASE = 64'h0000_0000_0010_0000;
  localparam logic [63:0] TBL_MASK = 64'h7F;
  localparam logic [63:0] K_CMP  = 64'hFFFF_FFFF_FFFF_FF83;
  localparam logic [63:0] K_AVPN = 64'h3FFF_FFFF_FFFF_FF80;
  localparam logic [63:0] K_VSID = 64'h3FFF_FFFF_FFFF_F000;
  localparam logic [63:0] K_RPN  = 64'h0FFF_FFFF_FFFF_F000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [VW-1:0] req_vsid = '0;
  logic req_seg_1t = 1'b0, lp_inhibit = 1'b0;
  logic [5:0] req_base_shift = 6'd12;
  logic [63:0] req_epn = '0;
  logic [NS*6-1:0] sz_shift_v = '0;
  logic [NS*EW-1:0] sz_code_v = '0;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [127:0] mem_rsp_data = '0;
  logic done, hit;
  logic [63:0] pte_offset, pte_word0, pte_word1;
  logic [5:0] page_shift;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpt_group_search dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vsid(req_vsid), .req_seg_1t(req_seg_1t), .req_base_shift(req_base_shift),
    .req_epn(req_epn), .lp_inhibit(lp_inhibit), .tbl_base(TBL_BASE), .tbl_mask(TBL_MASK),
    .sz_shift(sz_shift_v), .sz_code(sz_code_v),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .hit(hit), .pte_offset(pte_offset), .pte_word0(pte_word0),
    .pte_word1(pte_word1), .page_shift(page_shift)
  );

  int tests = 0, fails = 0;
  int sz_sh [NS];
  int sz_cd [NS];
  logic [127:0] mem [longint unsigned];
  longint unsigned exp_q [$];
  bit busy = 0, seen_done = 0, pend = 0, want_hit = 0;
  int dly = 0;
  string cur_tag = "R1";
  bit e_hit;
  logic [63:0] e_off, e_w0, e_w1;
  int e_sh;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] b_epnm(input logic [63:0] epn, input int sh);
    return epn & ~((64'd1 << sh) - 64'd1);
  endfunction

  function automatic logic [63:0] b_hash(input logic [63:0] v, input bit s1t, input int sh, input logic [63:0] epn);
    logic [63:0] pn = b_epnm(epn, sh) >> sh;
    return s1t ? (v ^ (v << 25) ^ pn) : (v ^ pn);
  endfunction

  function automatic logic [63:0] b_cmp(input logic [63:0] v, input bit s1t, input int sh, input logic [63:0] epn);
    logic [63:0] seg = s1t ? (64'h4000_0000_0000_0000 | ((v << 24) & K_VSID)) : ((v << 12) & K_VSID);
    return seg | ((b_epnm(epn, sh) >> 16) & K_AVPN) | 64'd1;
  endfunction

  function automatic logic [63:0] b_off(input logic [63:0] h, input bit sec, input int slot);
    logic [63:0] hh = sec ? ~h : h;
    return ((hh & TBL_MASK) << 7) + 64'(slot * 16);
  endfunction

  function automatic int b_decode(input int base, input logic [63:0] w0, input logic [63:0] w1);
    if (!w0[2]) return (base == 12) ? 12 : 0;
    for (int i = 0; i < NS; i++) begin
      if (sz_sh[i] == 0) return 0;
      if (sz_sh[i] != 12 &&
          ((w1 & ((64'd1 << sz_sh[i]) - 64'd1) & K_RPN) == (64'(sz_cd[i]) << 12)))
        return sz_sh[i];
    end
    return 0;
  endfunction

  task automatic set_sizes(input int s0, c0, s1, c1, s2, c2, s3, c3);
    sz_sh[0] = s0; sz_cd[0] = c0; sz_sh[1] = s1; sz_cd[1] = c1;
    sz_sh[2] = s2; sz_cd[2] = c2; sz_sh[3] = s3; sz_cd[3] = c3;
    for (int i = 0; i < NS; i++) begin
      sz_shift_v[i*6 +: 6] = 6'(sz_sh[i]);
      sz_code_v[i*EW +: EW] = EW'(sz_cd[i]);
    end
  endtask

  task automatic put(input logic [63:0] off, input logic [63:0] w0, input logic [63:0] w1);
    mem[TBL_BASE | off] = {w1, w0};
  endtask

  // behavioural reference: predicted reads and result
  task automatic ref_search(input logic [63:0] v, input bit s1t, input int base, input logic [63:0] epn, input bit inh);
    int sh = inh ? 12 : base;
    logic [63:0] h = b_hash(v, s1t, sh, epn);
    logic [63:0] c = b_cmp(v, s1t, sh, epn);
    bit found = 0;
    exp_q.delete();
    e_hit = 0; e_off = '0; e_w0 = '0; e_w1 = '0; e_sh = 0;
    for (int g = 0; g < 2; g++) begin
      for (int s = 0; s < 8; s++) begin
        if (!found) begin
          logic [63:0] off = b_off(h, g[0], s);
          logic [63:0] a = TBL_BASE | off;
          logic [127:0] d = mem.exists(a) ? mem[a] : 128'd0;
          exp_q.push_back(a);
          if (((d[63:0] ^ (c | (64'(g) << 1))) & K_CMP) == 64'd0) begin
            int ps = b_decode(sh, d[63:0], d[127:64]);
            if (ps != 0) begin
              found = 1; e_hit = 1; e_off = off; e_w0 = d[63:0]; e_w1 = d[127:64]; e_sh = ps;
            end
          end
        end
      end
    end
  endtask

  // one clock of memory model and per-cycle comparison
  task automatic step();
    @(negedge clk);
    if (mem_rsp_valid) mem_rsp_valid = 1'b0;
    if (pend) begin
      if (dly == 0) begin mem_rsp_valid = 1'b1; pend = 0; end
      else dly--;
    end
    mem_req_ready = (($urandom % 4) != 0);
    if (mem_req_valid && mem_req_ready) begin
      longint unsigned a = mem_req_addr;
      if (exp_q.size() == 0) chk(cur_tag, "unexpected read", mem_req_addr, 64'hFFFF_FFFF_FFFF_FFFF);
      else chk(cur_tag, "read address (R4 order)", mem_req_addr, exp_q.pop_front());
      mem_rsp_data = mem.exists(a) ? mem[a] : 128'd0;
      pend = 1; dly = $urandom % 3;
    end
    chk("R1", "req_ready vs idle", {63'd0, req_ready}, {63'd0, !busy});
    if (done) begin
      chk("R1", "done while busy", {63'd0, busy}, 64'd1);
      chk(cur_tag, "hit vs model", {63'd0, hit}, {63'd0, e_hit});
      chk(cur_tag, "hit vs intent", {63'd0, hit}, {63'd0, want_hit});
      chk(cur_tag, "page_shift", {58'd0, page_shift}, 64'(e_sh));
      if (e_hit) begin
        chk(cur_tag, "pte_offset R12", pte_offset, e_off);
        chk(cur_tag, "pte_word0 R12", pte_word0, e_w0);
        chk(cur_tag, "pte_word1 R12", pte_word1, e_w1);
      end
      chk(cur_tag, "reads outstanding at done", 64'(exp_q.size()), 64'd0);
      seen_done = 1; busy = 0;
    end
  endtask

  task automatic run_search(input string tag, input logic [63:0] v, input bit s1t, input int base,
                            input logic [63:0] epn, input bit inh, input bit wh);
    cur_tag = tag; want_hit = wh;
    ref_search(v, s1t, base, epn, inh);
    req_vsid = VW'(v); req_seg_1t = s1t; req_base_shift = 6'(base);
    req_epn = epn; lp_inhibit = inh;
    chk("R1", "req_ready before request", {63'd0, req_ready}, 64'd1);
    req_valid = 1'b1; busy = 1; seen_done = 0;
    step();
    req_valid = 1'b0;
    for (int n = 0; n < 3000 && !seen_done; n++) step();
    if (!seen_done) begin
      chk(tag, "watchdog: no done", 64'd0, 64'd1);
      busy = 0;
    end
    step();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL R1 global watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [63:0] h, c;
    set_sizes(12, 0, 16, 1, 24, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R1", "req_ready in reset", {63'd0, req_ready}, 64'd1);
    chk("R1", "done in reset", {63'd0, done}, 64'd0);
    chk("R4", "mem_req_valid in reset", {63'd0, mem_req_valid}, 64'd0);
    chk("R12", "page_shift in reset", {58'd0, page_shift}, 64'd0);
    rst_n = 1'b1;
    step();

    // R2 R5 R7: 256 MB, 4 KB page in slot 3, ignored bits 6:3 set
    mem.delete();
    h = b_hash(64'h123, 0, 12, 64'h0ABC_D000); c = b_cmp(64'h123, 0, 12, 64'h0ABC_D000);
    put(b_off(h, 0, 0), c & ~64'd1, 64'h1000);
    put(b_off(h, 0, 1), c ^ 64'h80, 64'h2000);
    put(b_off(h, 0, 2), c ^ 64'h4000_0000_0000_0000, 64'h3000);
    put(b_off(h, 0, 3), c | 64'h78 & ~64'h4, 64'hDEAD_B196);
    run_search("R2/R5/R7", 64'h123, 0, 12, 64'h0ABC_D000, 0, 1);

    // R6: primary entry with H set is not taken; secondary slot 5 hits
    mem.delete();
    h = b_hash(64'h4567, 0, 12, 64'h0123_4000); c = b_cmp(64'h4567, 0, 12, 64'h0123_4000);
    put(b_off(h, 0, 0), c | 64'h2, 64'h5000);
    put(b_off(h, 1, 5), c | 64'h2, 64'h6000);
    run_search("R6/R12", 64'h4567, 0, 12, 64'h0123_4000, 0, 1);

    // R3 R8 R9: 1 TB, base 16, slot 0 bad encoding skipped, slot 2 decodes to 16
    mem.delete();
    h = b_hash(64'h1_2345, 1, 16, 64'h12_3450_00); c = b_cmp(64'h1_2345, 1, 16, 64'h12_3450_00);
    put(b_off(h, 0, 0), c | 64'h4, 64'h1234_0000_2000);
    put(b_off(h, 0, 2), c | 64'h4, 64'h5670_1003);
    run_search("R3/R8/R9", 64'h1_2345, 1, 16, 64'h12_3450_00, 0, 1);

    // R7 R11: small-page entries in a base-16 segment are rejected, double miss
    mem.delete();
    h = b_hash(64'h77, 0, 16, 64'h0456_0000); c = b_cmp(64'h77, 0, 16, 64'h0456_0000);
    put(b_off(h, 0, 1), c, 64'h7000);
    put(b_off(h, 1, 7), c | 64'h2, 64'h8000);
    run_search("R7/R11", 64'h77, 0, 16, 64'h0456_0000, 0, 0);

    // R10: base 24 clamped to 12 by inhibit, small page accepted
    mem.delete();
    h = b_hash(64'h99, 0, 12, 64'h0765_4000); c = b_cmp(64'h99, 0, 12, 64'h0765_4000);
    put(b_off(h, 0, 4), c, 64'h9000);
    run_search("R10", 64'h99, 0, 24, 64'h0765_4000, 1, 1);

    // R8: walk stops at an empty slot ahead of the 16 MB slot
    set_sizes(16, 1, 0, 0, 24, 0, 0, 0);
    mem.delete();
    h = b_hash(64'h3_0303, 1, 16, 64'h00AB_0000); c = b_cmp(64'h3_0303, 1, 16, 64'h00AB_0000);
    put(b_off(h, 0, 0), c | 64'h4, 64'h0100_0000);
    put(b_off(h, 0, 6), c | 64'h4, 64'h0101_1000);
    run_search("R8/R9", 64'h3_0303, 1, 16, 64'h00AB_0000, 0, 1);

    // R8: 16 MB page in a base-24 segment
    set_sizes(12, 0, 16, 1, 24, 0, 0, 0);
    mem.delete();
    h = b_hash(64'hABC, 0, 24, 64'h0F12_3456); c = b_cmp(64'hABC, 0, 24, 64'h0F12_3456);
    put(b_off(h, 1, 2), c | 64'h6, 64'h3000_0000);
    run_search("R8/R6", 64'hABC, 0, 24, 64'h0F12_3456, 0, 1);

    // R11 R4: empty table, back-to-back misses under random stalls
    mem.delete();
    for (int k = 0; k < 3; k++)
      run_search("R11/R4", 64'(k * 1000 + 5), k[0], 12, 64'(k) << 20, 0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule